// File: doc/BRIEF.md
# Root Port Message Capture FIFOs

This block sits beside the receive path of a root-port style link controller. It captures two kinds of incoming message: error reports, each carrying a requester ID and a severity, and power-management event (PME) reports, each carrying a requester ID. Each kind goes into its own small FIFO. Software drains each FIFO through one register window per queue. A read of a window shows the head entry, with an in-band valid flag, and leaves the entry in place. A write of any value to the same window removes that entry.

An interrupt-decode register holds one sticky bit per error severity and one for PME arrivals. Software clears these bits by writing one to them. A control/status register reports whether each FIFO is non-empty and holds a sticky overflow bit per FIFO. The single interrupt output stays high while any decode bit is set. The usual service loop is: read the decode register, read entries from the window and pop them until the valid flag drops, then clear the decode bits.

Top module: `rpmc_top`

## Requirements
- R1: After reset, all sticky bits and both FIFOs are empty, `irq` is low, and every mapped register reads zero.
- R2: An error message (`err_valid` high for one cycle) is enqueued with its requester ID and severity. From the next cycle it sets the decode register at offset 0xE10: bit 9 for severity code 0 (correctable), bit 10 for code 1 (non-fatal), bit 11 for code 2 (fatal). Severity code 3 is stored and flagged as fatal (code 2, bit 11).
- R3: A PME message (`pme_valid` high) is enqueued with its requester ID and, from the next cycle, sets bit 17 of the decode register.
- R4: Writing offset 0xE10 clears each of bits 9, 10, 11 and 17 that is written as one. Bits written as zero keep their value. A flag that is set by a message in the same cycle as it is cleared stays set.
- R5: `irq` is high exactly while at least one of decode bits 9, 10, 11 or 17 is set.
- R6: At offset 0xE20, bit 16 reads one while the error FIFO holds an entry, and bit 18 reads one while the PME FIFO holds an entry.
- R7: A read of offset 0xE2C returns the error FIFO head as: requester ID in [15:0], severity code in [17:16], valid flag in bit 18, and zero above bit 18. The whole word is zero when the FIFO is empty. The read does not remove the entry.
- R8: A read of offset 0xE30 returns the PME FIFO head as: requester ID in [15:0], valid flag in bit 31, and zero elsewhere. The whole word is zero when the FIFO is empty.
- R9: A write of any data to 0xE2C or 0xE30 removes one entry from that FIFO. Entries leave in arrival order.
- R10: A window write to an empty FIFO changes nothing. A later push is then read back correctly as the head.
- R11: Each FIFO holds 8 entries. A message that arrives at a full FIFO with no pop in the same cycle is dropped. The drop sets a sticky overflow bit at 0xE20 (bit 17 for errors, bit 19 for PME), and the decode bit is still set. Writing one to the overflow bit clears it.
- R12: A push and a pop in the same cycle leave the entry count unchanged and keep the order. On a full FIFO the push is accepted and no overflow is flagged.
- R13: Reads of any offset other than 0xE10, 0xE20, 0xE2C or 0xE30 return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | Error message strobe |
| err_rid | input | 16 | Error message requester ID |
| err_sev | input | 2 | Error severity code (0 correctable, 1 non-fatal, 2 fatal) |
| pme_valid | input | 1 | PME message strobe |
| pme_rid | input | 16 | PME message requester ID |
| reg_addr | input | 12 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt, OR of the decode flags |

## Verification
The bench fills each FIFO past its eight entries. A design with an off-by-one in the count would keep a ninth entry or miss the overflow flag. It pushes and pops in the same cycle on an empty queue, on a part-filled queue and on a full queue. Wrong pointer handling there shows up as lost or reordered requester IDs, or as a false overflow. It writes a clear to the decode register in the same cycle a new message arrives, and it pops an empty queue. A design that let the clear win would drop a pending interrupt. A design that moved its pointers on an empty pop would return a stale or wrong head after the next push. Writes to unmapped offsets with all bits set catch a decoder that matches too loosely.

// File: rtl/rpmc_pkg.sv
package rpmc_pkg;

    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int RID_W      = 16;
    localparam int FIFO_DEPTH = 8;

    localparam logic [ADDR_W-1:0] OFS_INTDEC = 12'hE10;
    localparam logic [ADDR_W-1:0] OFS_CSR    = 12'hE20;
    localparam logic [ADDR_W-1:0] OFS_ERRWIN = 12'hE2C;
    localparam logic [ADDR_W-1:0] OFS_PMEWIN = 12'hE30;

    // decode register bit positions
    localparam int BIT_COR      = 9;
    localparam int BIT_NONFATAL = 10;
    localparam int BIT_FATAL    = 11;
    localparam int BIT_PME      = 17;

    // control/status bit positions
    localparam int BIT_ERR_NE   = 16;
    localparam int BIT_ERR_OVF  = 17;
    localparam int BIT_PME_NE   = 18;
    localparam int BIT_PME_OVF  = 19;

    // window valid flags
    localparam int BIT_ERR_VLD  = 18;
    localparam int BIT_PME_VLD  = 31;

    // index of each flag inside the internal sticky vector
    localparam int FLG_COR = 0, FLG_NONFATAL = 1, FLG_FATAL = 2, FLG_PME = 3;
    localparam int NFLAGS  = 4;
    localparam int OVF_ERR = 0, OVF_PME = 1;

    typedef enum logic [1:0] {
        SEV_COR      = 2'd0,
        SEV_NONFATAL = 2'd1,
        SEV_FATAL    = 2'd2
    } sev_e;

    typedef struct packed {
        sev_e             sev;
        logic [RID_W-1:0] rid;
    } err_entry_t;

    typedef struct packed {
        logic [RID_W-1:0] rid;
    } pme_entry_t;

    localparam int ERR_W = $bits(err_entry_t);
    localparam int PME_W = $bits(pme_entry_t);

    function automatic sev_e sev_norm(input logic [1:0] raw);
        return (raw == 2'd3) ? SEV_FATAL : sev_e'(raw);
    endfunction

    function automatic logic [DATA_W-1:0] err_window(input logic vld, input err_entry_t e);
        logic [DATA_W-1:0] w;
        w = '0;
        if (vld) begin
            w[ERR_W-1:0]  = e;
            w[BIT_ERR_VLD] = 1'b1;
        end
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pme_window(input logic vld, input pme_entry_t e);
        logic [DATA_W-1:0] w;
        w = '0;
        if (vld) begin
            w[PME_W-1:0]   = e;
            w[BIT_PME_VLD] = 1'b1;
        end
        return w;
    endfunction

endpackage

// File: rtl/rpmc_fifo.sv
module rpmc_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic         drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign drop    = push && !do_push;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    a_r11_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    a_r11_full_drop: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> full);

    a_r10_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> empty);

    a_r12_push_pop_keep: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !empty) |=> $stable(count));

endmodule

// File: rtl/rpmc_w1c.sv
module rpmc_w1c #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= (q & ~clr) | set;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> q[i]);
        a_r4_clr_only: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !set[i]) |=> !q[i]);
    end

endmodule

// File: rtl/rpmc_top.sv
module rpmc_top
    import rpmc_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              err_valid,
    input  logic [RID_W-1:0]  err_rid,
    input  logic [1:0]        err_sev,
    input  logic              pme_valid,
    input  logic [RID_W-1:0]  pme_rid,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    err_entry_t         err_in, err_head;
    pme_entry_t         pme_in, pme_head;
    logic               err_empty, err_full, err_drop, err_pop;
    logic               pme_empty, pme_full, pme_drop, pme_pop;
    logic [NFLAGS-1:0]  flag_set, flag_clr, flag_q;
    logic [1:0]         ovf_set, ovf_clr, ovf_q;
    logic               wr_intdec, wr_csr;
    logic [DATA_W-1:0]  rd_intdec, rd_csr;

    assign err_in.sev = sev_norm(err_sev);
    assign err_in.rid = err_rid;
    assign pme_in.rid = pme_rid;

    assign err_pop   = reg_wr && (reg_addr == OFS_ERRWIN);
    assign pme_pop   = reg_wr && (reg_addr == OFS_PMEWIN);
    assign wr_intdec = reg_wr && (reg_addr == OFS_INTDEC);
    assign wr_csr    = reg_wr && (reg_addr == OFS_CSR);

    rpmc_fifo #(.W(ERR_W), .DEPTH(DEPTH)) u_err_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (err_valid),
        .pop   (err_pop),
        .din   (err_in),
        .head  (err_head),
        .empty (err_empty),
        .full  (err_full),
        .drop  (err_drop)
    );

    rpmc_fifo #(.W(PME_W), .DEPTH(DEPTH)) u_pme_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (pme_valid),
        .pop   (pme_pop),
        .din   (pme_in),
        .head  (pme_head),
        .empty (pme_empty),
        .full  (pme_full),
        .drop  (pme_drop)
    );

    always_comb begin
        flag_set               = '0;
        flag_set[FLG_COR]      = err_valid && (err_in.sev == SEV_COR);
        flag_set[FLG_NONFATAL] = err_valid && (err_in.sev == SEV_NONFATAL);
        flag_set[FLG_FATAL]    = err_valid && (err_in.sev == SEV_FATAL);
        flag_set[FLG_PME]      = pme_valid;

        flag_clr               = '0;
        flag_clr[FLG_COR]      = wr_intdec && reg_wdata[BIT_COR];
        flag_clr[FLG_NONFATAL] = wr_intdec && reg_wdata[BIT_NONFATAL];
        flag_clr[FLG_FATAL]    = wr_intdec && reg_wdata[BIT_FATAL];
        flag_clr[FLG_PME]      = wr_intdec && reg_wdata[BIT_PME];

        ovf_set                = '0;
        ovf_set[OVF_ERR]       = err_drop;
        ovf_set[OVF_PME]       = pme_drop;
        ovf_clr                = '0;
        ovf_clr[OVF_ERR]       = wr_csr && reg_wdata[BIT_ERR_OVF];
        ovf_clr[OVF_PME]       = wr_csr && reg_wdata[BIT_PME_OVF];
    end

    rpmc_w1c #(.N(NFLAGS)) u_flags (
        .clk (clk),
        .rst (rst),
        .set (flag_set),
        .clr (flag_clr),
        .q   (flag_q)
    );

    rpmc_w1c #(.N(2)) u_ovf (
        .clk (clk),
        .rst (rst),
        .set (ovf_set),
        .clr (ovf_clr),
        .q   (ovf_q)
    );

    always_comb begin
        rd_intdec               = '0;
        rd_intdec[BIT_COR]      = flag_q[FLG_COR];
        rd_intdec[BIT_NONFATAL] = flag_q[FLG_NONFATAL];
        rd_intdec[BIT_FATAL]    = flag_q[FLG_FATAL];
        rd_intdec[BIT_PME]      = flag_q[FLG_PME];

        rd_csr                  = '0;
        rd_csr[BIT_ERR_NE]      = !err_empty;
        rd_csr[BIT_ERR_OVF]     = ovf_q[OVF_ERR];
        rd_csr[BIT_PME_NE]      = !pme_empty;
        rd_csr[BIT_PME_OVF]     = ovf_q[OVF_PME];
    end

    always_comb begin
        unique case (reg_addr)
            OFS_INTDEC: reg_rdata = rd_intdec;
            OFS_CSR:    reg_rdata = rd_csr;
            OFS_ERRWIN: reg_rdata = err_window(!err_empty, err_head);
            OFS_PMEWIN: reg_rdata = pme_window(!pme_empty, pme_head);
            default:    reg_rdata = '0;
        endcase
    end

    assign irq = |flag_q;

    logic wdata_unused;
    assign wdata_unused = ^reg_wdata;

    a_r2_fatal_flag: assert property (@(posedge clk) disable iff (rst)
        (err_valid && (err_sev[1] == 1'b1)) |=> rd_intdec[BIT_FATAL]);

    a_r3_pme_flag: assert property (@(posedge clk) disable iff (rst)
        pme_valid |=> irq);

    a_r11_err_ovf: assert property (@(posedge clk) disable iff (rst)
        (err_valid && err_full && !err_pop) |=> ovf_q[OVF_ERR]);

    a_r11_pme_ovf: assert property (@(posedge clk) disable iff (rst)
        (pme_valid && pme_full && !pme_pop) |=> ovf_q[OVF_PME]);

    a_r12_full_swap_no_ovf: assert property (@(posedge clk) disable iff (rst)
        (err_valid && err_full && err_pop && !ovf_q[OVF_ERR]) |=> !ovf_q[OVF_ERR]);

    a_r13_unmapped_no_pop: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr != OFS_ERRWIN && !err_valid) |=> $stable(err_empty));

endmodule

// File: tb/test_rpmc_top.sv
`timescale 1ns/1ps
module test_rpmc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        err_valid = 1'b0;
    logic [15:0] err_rid = '0;
    logic [1:0]  err_sev = '0;
    logic        pme_valid = 1'b0;
    logic [15:0] pme_rid = '0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [11:0] A_DEC = 12'hE10, A_CSR = 12'hE20, A_ERR = 12'hE2C, A_PME = 12'hE30;

    always #2.5 clk = ~clk;

    rpmc_top i_rpmc_top (
        .clk(clk), .rst(rst),
        .err_valid(err_valid), .err_rid(err_rid), .err_sev(err_sev),
        .pme_valid(pme_valid), .pme_rid(pme_rid),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a;
        #0.5;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic push_err(input logic [15:0] rid, input logic [1:0] sev);
        err_valid = 1'b1; err_rid = rid; err_sev = sev;
        @(negedge clk);
        err_valid = 1'b0;
    endtask

    task automatic push_pme(input logic [15:0] rid);
        pme_valid = 1'b1; pme_rid = rid;
        @(negedge clk);
        pme_valid = 1'b0;
    endtask

    function automatic logic [31:0] ew(input logic [15:0] rid, input logic [1:0] sev);
        return {13'd0, 1'b1, sev, rid};
    endfunction

    task automatic t_reset();
        rd_chk("R1 decode after reset", A_DEC, 32'h0);
        rd_chk("R1 csr after reset", A_CSR, 32'h0);
        rd_chk("R1 err window after reset", A_ERR, 32'h0);
        rd_chk("R1 pme window after reset", A_PME, 32'h0);
        chk("R1 irq after reset", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_err_order();
        push_err(16'h0A01, 2'd0);
        push_err(16'h0A02, 2'd1);
        push_err(16'h0A03, 2'd2);
        push_err(16'h0A04, 2'd3);
        rd_chk("R2 decode severity bits", A_DEC, 32'h0000_0E00);
        chk("R5 irq with error flags", {31'd0, irq}, 32'h1);
        rd_chk("R6 csr err not empty", A_CSR, 32'h0001_0000);
        rd_chk("R7 err head", A_ERR, ew(16'h0A01, 2'd0));
        rd_chk("R7 err head read again", A_ERR, ew(16'h0A01, 2'd0));
        wr(A_ERR, 32'hFFFF_FFFF);
        rd_chk("R9 err second", A_ERR, ew(16'h0A02, 2'd1));
        wr(A_ERR, 32'h0);
        rd_chk("R9 err third", A_ERR, ew(16'h0A03, 2'd2));
        wr(A_ERR, 32'h1234_5678);
        rd_chk("R2 severity 3 stored as fatal", A_ERR, ew(16'h0A04, 2'd2));
        wr(A_ERR, 32'h0);
        rd_chk("R7 err window empty", A_ERR, 32'h0);
        rd_chk("R6 csr err empty", A_CSR, 32'h0);
    endtask

    task automatic t_w1c();
        wr(A_DEC, 32'h0000_0200);
        rd_chk("R4 clear bit9 only", A_DEC, 32'h0000_0C00);
        wr(A_DEC, 32'h0);
        rd_chk("R4 write zero keeps", A_DEC, 32'h0000_0C00);
        chk("R5 irq still high", {31'd0, irq}, 32'h1);
        wr(A_DEC, 32'hFFFF_FFFF);
        rd_chk("R4 clear all", A_DEC, 32'h0);
        chk("R5 irq low when clear", {31'd0, irq}, 32'h0);
        // clear and set in the same cycle
        err_valid = 1'b1; err_rid = 16'h0B00; err_sev = 2'd0;
        reg_addr = A_DEC; reg_wdata = 32'h0000_0200; reg_wr = 1'b1;
        @(negedge clk);
        err_valid = 1'b0; reg_wr = 1'b0;
        rd_chk("R4 set wins over clear", A_DEC, 32'h0000_0200);
        wr(A_ERR, 32'h0);
        wr(A_DEC, 32'h0002_0E00);
        rd_chk("R4 decode cleared", A_DEC, 32'h0);
    endtask

    task automatic t_pme();
        push_pme(16'hBEEF);
        push_pme(16'h0042);
        rd_chk("R3 pme decode bit", A_DEC, 32'h0002_0000);
        chk("R5 irq on pme", {31'd0, irq}, 32'h1);
        rd_chk("R6 csr pme not empty", A_CSR, 32'h0004_0000);
        rd_chk("R8 pme head", A_PME, 32'h8000_BEEF);
        wr(A_PME, 32'hDEAD_0000);
        rd_chk("R9 pme second", A_PME, 32'h8000_0042);
        wr(A_PME, 32'h0);
        rd_chk("R8 pme window empty", A_PME, 32'h0);
        wr(A_DEC, 32'h0002_0000);
        chk("R5 irq low after pme clear", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_empty_pop();
        wr(A_ERR, 32'h0);
        wr(A_PME, 32'h0);
        rd_chk("R10 csr after empty pops", A_CSR, 32'h0);
        push_err(16'h0C01, 2'd1);
        push_pme(16'h0C02);
        rd_chk("R10 err head after empty pop", A_ERR, ew(16'h0C01, 2'd1));
        rd_chk("R10 pme head after empty pop", A_PME, 32'h8000_0C02);
        wr(A_ERR, 32'h0);
        wr(A_PME, 32'h0);
        rd_chk("R10 csr drained", A_CSR, 32'h0);
        wr(A_DEC, 32'h0002_0E00);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 9; i++) push_err(16'h0100 + 16'(i), 2'd0);
        rd_chk("R11 err overflow flagged", A_CSR, 32'h0003_0000);
        for (int i = 0; i < 8; i++) begin
            rd_chk("R11 err entry in order", A_ERR, ew(16'h0100 + 16'(i), 2'd0));
            wr(A_ERR, 32'h0);
        end
        rd_chk("R11 ninth err dropped", A_ERR, 32'h0);
        rd_chk("R11 err ovf sticky", A_CSR, 32'h0002_0000);
        wr(A_CSR, 32'h0002_0000);
        rd_chk("R11 err ovf cleared", A_CSR, 32'h0);
        for (int i = 0; i < 9; i++) push_pme(16'h0200 + 16'(i));
        rd_chk("R11 pme overflow flagged", A_CSR, 32'h000C_0000);
        rd_chk("R11 decode set on drop", A_DEC, 32'h0002_0200);
        wr(A_CSR, 32'h0008_0000);
        rd_chk("R11 pme ovf cleared", A_CSR, 32'h0004_0000);
        for (int i = 0; i < 8; i++) begin
            rd_chk("R11 pme entry in order", A_PME, 32'h8000_0200 + 32'(i));
            wr(A_PME, 32'h0);
        end
        rd_chk("R11 ninth pme dropped", A_PME, 32'h0);
        wr(A_DEC, 32'h0002_0E00);
    endtask

    task automatic push_pop_err(input logic [15:0] rid);
        err_valid = 1'b1; err_rid = rid; err_sev = 2'd1;
        reg_addr = A_ERR; reg_wdata = 32'h0; reg_wr = 1'b1;
        @(negedge clk);
        err_valid = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic t_simul();
        push_pop_err(16'h03AA);
        rd_chk("R12 empty push+pop keeps push", A_ERR, ew(16'h03AA, 2'd1));
        wr(A_ERR, 32'h0);
        push_err(16'h0401, 2'd1);
        push_err(16'h0402, 2'd1);
        push_pop_err(16'h0403);
        rd_chk("R12 order after push+pop", A_ERR, ew(16'h0402, 2'd1));
        wr(A_ERR, 32'h0);
        rd_chk("R12 pushed entry follows", A_ERR, ew(16'h0403, 2'd1));
        wr(A_ERR, 32'h0);
        rd_chk("R12 count kept", A_ERR, 32'h0);
        for (int i = 0; i < 8; i++) push_err(16'h0500 + 16'(i), 2'd1);
        push_pop_err(16'h05FF);
        rd_chk("R12 full push+pop no overflow", A_CSR, 32'h0001_0000);
        for (int i = 1; i < 8; i++) begin
            rd_chk("R12 full swap order", A_ERR, ew(16'h0500 + 16'(i), 2'd1));
            wr(A_ERR, 32'h0);
        end
        rd_chk("R12 swapped entry last", A_ERR, ew(16'h05FF, 2'd1));
        wr(A_ERR, 32'h0);
        rd_chk("R12 drained", A_CSR, 32'h0);
        wr(A_DEC, 32'h0002_0E00);
    endtask

    task automatic t_unmapped();
        push_err(16'h0D01, 2'd2);
        push_pme(16'h0D02);
        wr(12'hE14, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        wr(12'hE28, 32'hFFFF_FFFF);
        rd_chk("R13 unmapped read E14", 12'hE14, 32'h0);
        rd_chk("R13 unmapped read FFF", 12'hFFF, 32'h0);
        rd_chk("R13 decode untouched", A_DEC, 32'h0002_0800);
        rd_chk("R13 err fifo untouched", A_ERR, ew(16'h0D01, 2'd2));
        rd_chk("R13 pme fifo untouched", A_PME, 32'h8000_0D02);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R1-flow actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_err_order();
        t_w1c();
        t_pme();
        t_empty_pop();
        t_overflow();
        t_simul();
        t_unmapped();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule